// File: doc/BRIEF.md
# Serial Receiver with Line Status

This block receives asynchronous serial characters on a single line and holds them in a small queue for a reader. A 16x oversampling enable paces the bit timing. Each character has one start bit, eight data bits sent least significant bit first, an even parity bit and one stop bit. Every character goes into a 16-entry queue together with a flag that records whether its parity was wrong.

A read-only status word reports three conditions:
- data available;
- a character lost because the queue was full;
- a parity mismatch on the character at the head of the queue.

The two error bits are sticky. Only a status read clears them, and a data read leaves them alone. If an error event and a status read fall in the same cycle, the error wins.

Top module: `uart_rx_lsr`

## Requirements
- R1: `stat_o[0]` (data ready) is 1 exactly when the queue holds at least one unread character. The status encoding is bit0 data ready, bit1 overrun, bit2 parity error.
- R2: Bit timing and byte output.
  - A frame is timed in `tick_i` pulses, 16 per bit.
  - A low line is confirmed as a start bit at the 8th tick. The 8 data bits are then sampled 16 ticks apart, least significant bit first.
  - `data_o` shows the byte at the head of the queue.
  - A data read removes that byte.
- R3: `stat_o[1]` (overrun) is set when a character completes while the queue already holds 16 entries. It stays set through data reads. A status read clears it.
- R4: When an overrun occurs, the 16 queued characters are kept unchanged and the new character is discarded.
- R5: Parity is even: the data bits plus the parity bit carry an even number of ones. A character that breaks this rule is flagged, and `stat_o[2]` rises when that character reaches the head of the queue.
- R6: A status read clears `stat_o[2]`. The flag is not raised again for the same head character. A flagged character that later reaches the head raises it again.
- R7: After reset, `stat_o` is 0 and `data_o` is 0.
- R8: A data read while the queue is empty has no effect: `data_o` stays 0 and `stat_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling enable, 16 per bit time |
| rd_data_i | input | 1 | Pop the head character |
| rd_stat_i | input | 1 | Status read strobe; clears the sticky error bits |
| data_o | output | 8 | Head character, 0 when the queue is empty |
| stat_o | output | 3 | {parity error, overrun, data ready} |

## Verification
A wrong queue count or pointer shows at the ports as soon as the affected entry reaches the head. The symptom is a wrong byte on `data_o` or a data-ready bit that disagrees with the number of characters sent minus those read. That is why every byte value is pushed and popped, and why a full queue is drained with each byte compared. A broken sticky bit or head-report tracker shows within a few cycles of a status read: an error bit that never clears, or one that comes back for a character already reported. The bench probes both of these after every status read.

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              rd_data_i,
  input  logic              rd_stat_i,
  output logic [DATA_W-1:0] data_o,
  output logic [2:0]        stat_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DATA_W + 1);
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t               st;
  logic [1:0]        sync;
  logic              rx_s;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     nbits;
  logic [DATA_W-1:0] shreg;
  logic              pbad;
  logic              done;

  logic [DATA_W:0]   mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       count;
  logic              empty, full, push, pop;
  logic              ovr_q, pe_q, rep_q;
  logic              ovr_evt, pe_evt;

  assign rx_s = sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      nbits <= '0;
      shreg <= '0;
      pbad  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick_i) begin
        case (st)
          S_IDLE:
            if (!rx_s) begin
              st  <= S_START;
              cnt <= '0;
            end
          S_START:
            if (cnt == CW'(HALF - 1)) begin
              cnt   <= '0;
              nbits <= '0;
              st    <= rx_s ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (cnt == CW'(OVS - 1)) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[DATA_W-1:1]};
              nbits <= nbits + 1'b1;
              if (nbits == BW'(DATA_W - 1)) st <= S_PAR;
            end else cnt <= cnt + 1'b1;
          S_PAR:
            if (cnt == CW'(OVS - 1)) begin
              cnt  <= '0;
              pbad <= rx_s ^ (^shreg);
              st   <= S_STOP;
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (cnt == CW'(OVS - 1)) begin
              cnt  <= '0;
              done <= 1'b1;
              st   <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign push    = done && !full;
  assign pop     = rd_data_i && !empty;
  assign ovr_evt = done && full;
  assign pe_evt  = !empty && mem[rp][DATA_W] && !rep_q;

  always_ff @(posedge clk)
    if (push) mem[wp] <= {pbad, shreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      pe_q  <= 1'b0;
      rep_q <= 1'b0;
    end else begin
      ovr_q <= ovr_evt || (ovr_q && !rd_stat_i);
      pe_q  <= pe_evt  || (pe_q  && !rd_stat_i);
      if (pop)         rep_q <= 1'b0;
      else if (pe_evt) rep_q <= 1'b1;
    end
  end

  assign data_o = empty ? '0 : mem[rp][DATA_W-1:0];
  assign stat_o = {pe_q, ovr_q, !empty};

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH)); // R1

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_data_i && !done) |=> empty); // R8

  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && done && !rd_data_i) |=> (full && ovr_q && $stable(wp))); // R4

  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_i && !(done && full)) |=> !ovr_q); // R3

  AST_PE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_i && !pe_evt) |=> !pe_q); // R6
endmodule

// File: tb/uart_rx_lsr_tb.sv
module uart_rx_lsr_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rx = 1;
  logic       tick = 1;
  logic       rd_data = 0;
  logic       rd_stat = 0;
  logic [7:0] data_o;
  logic [2:0] stat_o;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  uart_rx_lsr u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick),
    .rd_data_i(rd_data), .rd_stat_i(rd_stat),
    .data_o(data_o), .stat_o(stat_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitout(input logic v);
    rx = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic wrong_par);
    bitout(1'b0);
    for (int i = 0; i < 8; i++) bitout(b[i]);
    bitout((^b) ^ wrong_par);
    bitout(1'b1);
    repeat (6) @(negedge clk);
  endtask

  task automatic pop();
    rd_data = 1; @(negedge clk); rd_data = 0; repeat (3) @(negedge clk);
  endtask

  task automatic sread();
    rd_stat = 1; @(negedge clk); rd_stat = 0; repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 status after reset", stat_o, 0);
    chk("R7 data after reset", data_o, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    pop();
    chk("R8 empty read status", stat_o, 0);
    chk("R8 empty read data", data_o, 0);

    for (int b = 0; b < 256; b++) begin
      logic wp;
      wp = (b % 7) == 3;
      send(8'(b), wp);
      chk("R2 byte at head", data_o, b);
      chk("R1 ready set", stat_o[0], 1);
      chk("R5 parity flag", stat_o[2], int'(wp));
      chk("R3 no overrun", stat_o[1], 0);
      if (wp) begin
        sread();
        chk("R6 cleared by status read", stat_o, 3'b001);
      end
      pop();
      chk("R1 ready clear after pop", stat_o, 0);
    end

    for (int i = 0; i < 16; i++) send(8'hA0 + 8'(i), 1'b0);
    chk("R3 full, no overrun yet", stat_o, 3'b001);
    send(8'h5C, 1'b0);
    chk("R3 overrun set", stat_o, 3'b011);
    for (int i = 0; i < 16; i++) begin
      chk("R4 kept contents", data_o, 8'hA0 + i);
      pop();
    end
    chk("R3 sticky through data reads", stat_o, 3'b010);
    chk("R4 new char dropped", data_o, 0);
    sread();
    chk("R3 cleared by status read", stat_o, 0);

    send(8'h11, 1'b0);
    send(8'h22, 1'b1);
    send(8'h33, 1'b0);
    send(8'h44, 1'b1);
    chk("R5 good head no flag", stat_o, 3'b001);
    pop();
    chk("R5 flagged head data", data_o, 8'h22);
    chk("R5 flagged head reported", stat_o, 3'b101);
    sread();
    chk("R6 not raised again same head", stat_o, 3'b001);
    pop();
    chk("R6 good head after pop", stat_o, 3'b001);
    chk("R2 next byte", data_o, 8'h33);
    pop();
    chk("R6 next flagged head raises", stat_o, 3'b101);
    pop();
    chk("R6 sticky after data read", stat_o, 3'b100);
    sread();
    chk("R1 all drained", stat_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule